// File: doc/BRIEF.md
# Serial Port Flag and Interrupt Register Block

This block is the register front end of a serial port. It keeps six status flags (receive-ready, transmit-ready, overrun, break, framing error, parity error) together with one interrupt enable per flag. It drives a single level interrupt line. Software reads the flags in the status word. It changes them only through a write-only command word, where each flag has its own set bit and its own clear bit, so no read-modify-write is needed. The same command word also issues one-cycle strobes that pop the receive FIFO and flush either FIFO.

Two flags also follow hardware conditions. Transmit-ready is raised whenever the transmit FIFO holds no more characters than a 4-bit threshold. Receive-ready is raised only after the receive FIFO has stayed non-empty for a programmable number of bit-time ticks, so a burst of characters can collect before the first interrupt.

The register bus never stalls. A write takes effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. The transmit push is a fire-and-forget strobe: software must check the transmit count in the status word before writing the data word, because the block offers no back-pressure.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset the control word, the baud word, the five receive-side flags and `irq` are all zero. Transmit-ready becomes 1 on the first edge after reset, because a count of 0 is within the reset threshold of 0.
- R2: Byte offset 4 is the control word, with bits 25:0 writable and readable and bits 31:26 reading 0. Offset 8 is the baud word, with bits 15:0 writable, readable and driven on `baud_cfg`. A read of offset 0 returns `rx_head` in bits 7:0. A read of offset 12 (command) returns 0.
- R3: Offset 16 is the read-only status word. Bit 0 is receive-ready, bit 1 transmit-ready, bit 2 overrun, bit 3 break, bit 4 framing error and bit 5 parity error. Bits 10:6 carry `rx_count` and bits 15:11 carry `tx_count`.
- R4: A one-cycle pulse on `ev_overrun`, `ev_break`, `ev_frame` or `ev_parity` sets the matching status flag at that edge. The flag then stays set until software clears it.
- R5: A write to offset 12 acts at its edge. Bits 0..4 clear receive-ready, overrun, break, framing and parity. Bits 5..9 set the same five flags in that order. Bit 13 clears transmit-ready and bit 14 sets it.
- R6: If a hardware set condition and a command clear hit one flag in the same cycle, the flag ends up 1. If the set and clear bits for one flag are written together, the flag also ends up 1.
- R7: Transmit-ready is forced to 1 on every edge where `tx_count` is less than or equal to control bits 25:22. A clear therefore only takes hold while the count is above the threshold.
- R8: Control bits 21:14 hold a delay D. Once `rx_count` leaves zero, `bit_tick` pulses are counted. Receive-ready is set on the edge after the D-th counted tick, or on the edge after the FIFO becomes non-empty if D is 0. Ticks while the FIFO is empty are ignored, and the count restarts whenever `rx_count` returns to zero.
- R9: `irq` is the OR of each flag ANDed with its enable. Control bit 0 enables receive-ready, bit 1 overrun, bit 2 break, bit 3 framing, bit 4 parity and bit 5 transmit-ready.
- R10: During a command write cycle, bit 10 drives `rx_pull`, bit 11 drives `rx_flush` and bit 12 drives `tx_flush`, each high for that cycle only. A write to offset 0 drives `tx_push` for that cycle, with `tx_char` equal to write bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rx_head | input | 8 | Character at the head of the receive FIFO |
| rx_count | input | 5 | Receive FIFO occupancy |
| tx_count | input | 5 | Transmit FIFO occupancy |
| ev_overrun | input | 1 | Receive overrun pulse |
| ev_break | input | 1 | Break detected pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| bit_tick | input | 1 | One pulse per bit time |
| irq | output | 1 | Interrupt request, level |
| rx_pull | output | 1 | Pop one character from the receive FIFO |
| rx_flush | output | 1 | Empty the receive FIFO |
| tx_flush | output | 1 | Empty the transmit FIFO |
| tx_push | output | 1 | Push `tx_char` into the transmit FIFO |
| tx_char | output | 8 | Character to push |
| baud_cfg | output | 16 | Baud word for the rate generator |

## Verification
The bench sweeps every threshold against every transmit count from 0 to 16. A comparison that is off by one, or that uses strict less-than, would leave transmit-ready wrong exactly on the diagonal. It pairs each flag with each single enable bit, so a swapped enable mapping would raise `irq` from the wrong flag. It runs the receive delay one tick short and one tick complete for several delays, including zero, and drains the FIFO partway through a count: a counter that does not restart, or one that counts ticks while the FIFO is empty, would raise receive-ready early. Same-cycle collisions between an error pulse and a clear, and between a set bit and a clear bit, catch a priority order written backwards.

// File: rtl/usi_pkg.sv
package usi_pkg;

  localparam int NFLAGS = 6;

  // flag order inside the status word
  localparam int F_RRDY = 0;
  localparam int F_TRDY = 1;
  localparam int F_OE   = 2;
  localparam int F_BRK  = 3;
  localparam int F_FE   = 4;
  localparam int F_PE   = 5;

  localparam logic [4:0] OFS_DATA = 5'd0;
  localparam logic [4:0] OFS_CTRL = 5'd4;
  localparam logic [4:0] OFS_BAUD = 5'd8;
  localparam logic [4:0] OFS_CMD  = 5'd12;
  localparam logic [4:0] OFS_STAT = 5'd16;

  localparam int CMD_RX_PULL  = 10;
  localparam int CMD_RX_FLUSH = 11;
  localparam int CMD_TX_FLUSH = 12;

  localparam int CTL_DLY_LSB = 14;
  localparam int STAT_CNT_LSB = 6;

  // control bit enabling flag f
  function automatic int ie_pos(input int f);
    case (f)
      F_RRDY:  return 0;
      F_OE:    return 1;
      F_BRK:   return 2;
      F_FE:    return 3;
      F_PE:    return 4;
      default: return 5;
    endcase
  endfunction

  // command bit setting flag f
  function automatic int set_pos(input int f);
    case (f)
      F_RRDY:  return 5;
      F_OE:    return 6;
      F_BRK:   return 7;
      F_FE:    return 8;
      F_PE:    return 9;
      default: return 14;
    endcase
  endfunction

  // command bit clearing flag f
  function automatic int clr_pos(input int f);
    case (f)
      F_RRDY:  return 0;
      F_OE:    return 1;
      F_BRK:   return 2;
      F_FE:    return 3;
      F_PE:    return 4;
      default: return 13;
    endcase
  endfunction

endpackage

// File: rtl/usi_flag_cell.sv
module usi_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (hw_set || sw_set)  flag <= 1'b1;
    else if (sw_clr)            flag <= 1'b0;
  end

  AST_HW_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && sw_clr) |=> flag); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !sw_set && !hw_set) |=> !flag); // R5

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_set && !sw_set && !sw_clr) |=> $stable(flag)); // R4

endmodule

// File: rtl/usi_rx_delay.sv
module usi_rx_delay #(
  parameter int CNT_W = 5,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             bit_tick,
  input  logic [DLY_W-1:0] delay,
  output logic             hit
);

  localparam logic [DLY_W-1:0] TICK_MAX = '1;

  logic [DLY_W-1:0] ticks;
  logic             nonempty;

  assign nonempty = (rx_count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !nonempty)                 ticks <= '0;
    else if (bit_tick && ticks != TICK_MAX)  ticks <= ticks + 1'b1;
  end

  assign hit = nonempty && (ticks >= delay);

  AST_ZERO_DELAY_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (delay == '0 && rx_count != '0) |-> hit); // R8

  AST_EMPTY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> (ticks == '0)); // R8

endmodule

// File: rtl/usi_irq_merge.sv
module usi_irq_merge #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] flags,
  input  logic [NF-1:0] enables,
  output logic          irq
);

  assign irq = |(flags & enables);

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0 && enables != '0)); // R9

endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5,
  parameter int CHAR_W = 8,
  parameter int DLY_W  = 8,
  parameter int THR_W  = 4,
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CHAR_W-1:0] rx_head,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              ev_overrun,
  input  logic              ev_break,
  input  logic              ev_frame,
  input  logic              ev_parity,
  input  logic              bit_tick,
  output logic              irq,
  output logic              rx_pull,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic              tx_push,
  output logic [CHAR_W-1:0] tx_char,
  output logic [BAUD_W-1:0] baud_cfg
);
  import usi_pkg::*;

  localparam int THR_LSB = CTL_DLY_LSB + DLY_W;
  localparam int CTL_W   = THR_LSB + THR_W;
  localparam int TXC_LSB = STAT_CNT_LSB + CNT_W;

  logic [CTL_W-1:0]  ctrl_q;
  logic [BAUD_W-1:0] baud_q;
  logic              sel_data, sel_ctrl, sel_baud, sel_cmd;
  logic [DATA_W-1:0] cmd;
  logic [NFLAGS-1:0] hw_evt, flags, enables;
  logic [THR_W-1:0]  tx_thr;
  logic [DLY_W-1:0]  rx_dly;
  logic              rx_hit, tx_low;
  logic [DATA_W-1:0] stat_word;
  logic              unused_wbits;

  assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_baud = (bus_addr == ADDR_W'(OFS_BAUD));
  assign sel_cmd  = (bus_addr == ADDR_W'(OFS_CMD));

  assign cmd = (bus_wr && sel_cmd) ? bus_wdata : '0;
  assign unused_wbits = ^bus_wdata[DATA_W-1:CTL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      baud_q <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl) ctrl_q <= bus_wdata[CTL_W-1:0];
      if (sel_baud) baud_q <= bus_wdata[BAUD_W-1:0];
    end
  end

  assign rx_dly   = ctrl_q[CTL_DLY_LSB +: DLY_W];
  assign tx_thr   = ctrl_q[THR_LSB +: THR_W];
  assign baud_cfg = baud_q;

  usi_rx_delay #(.CNT_W(CNT_W), .DLY_W(DLY_W)) rx_delay_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_count (rx_count),
    .bit_tick (bit_tick),
    .delay    (rx_dly),
    .hit      (rx_hit)
  );

  assign tx_low = (int'(tx_count) <= int'(tx_thr));

  always_comb begin
    hw_evt         = '0;
    hw_evt[F_RRDY] = rx_hit;
    hw_evt[F_TRDY] = tx_low;
    hw_evt[F_OE]   = ev_overrun;
    hw_evt[F_BRK]  = ev_break;
    hw_evt[F_FE]   = ev_frame;
    hw_evt[F_PE]   = ev_parity;
  end

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    usi_flag_cell cell_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (hw_evt[g]),
      .sw_set (cmd[set_pos(g)]),
      .sw_clr (cmd[clr_pos(g)]),
      .flag   (flags[g])
    );
    assign enables[g] = ctrl_q[ie_pos(g)];
  end

  usi_irq_merge #(.NF(NFLAGS)) irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .enables (enables),
    .irq     (irq)
  );

  assign rx_pull  = cmd[CMD_RX_PULL];
  assign rx_flush = cmd[CMD_RX_FLUSH];
  assign tx_flush = cmd[CMD_TX_FLUSH];
  assign tx_push  = bus_wr && sel_data;
  assign tx_char  = bus_wdata[CHAR_W-1:0];

  always_comb begin
    stat_word = '0;
    stat_word[NFLAGS-1:0] = flags;
    stat_word[STAT_CNT_LSB +: CNT_W] = rx_count;
    stat_word[TXC_LSB +: CNT_W] = tx_count;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_DATA): bus_rdata[CHAR_W-1:0] = rx_head;
      ADDR_W'(OFS_CTRL): bus_rdata[CTL_W-1:0]  = ctrl_q;
      ADDR_W'(OFS_BAUD): bus_rdata[BAUD_W-1:0] = baud_q;
      ADDR_W'(OFS_STAT): bus_rdata = stat_word;
      default:           bus_rdata = '0;
    endcase
  end

  AST_TRDY_TRACKS_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_low |=> flags[F_TRDY]); // R7

  AST_ERROR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame || ev_parity) |=> (flags[F_FE] || flags[F_PE])); // R4

  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pull || rx_flush || tx_flush || tx_push) |-> bus_wr); // R10

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[5] && cmd[0]) |=> flags[F_RRDY]); // R6

endmodule

// File: tb/uart_stat_irq_tb_top.sv
`timescale 1ns/1ps
module uart_stat_irq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_head = 8'h00;
  logic [4:0]  rx_count = '0;
  logic [4:0]  tx_count = '0;
  logic [3:0]  ev = '0;
  logic        bit_tick = 1'b0;
  logic        irq, rx_pull, rx_flush, tx_flush, tx_push;
  logic [7:0]  tx_char;
  logic [15:0] baud_cfg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_stat_irq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_head(rx_head),
    .rx_count(rx_count), .tx_count(tx_count),
    .ev_overrun(ev[0]), .ev_break(ev[1]), .ev_frame(ev[2]), .ev_parity(ev[3]),
    .bit_tick(bit_tick), .irq(irq), .rx_pull(rx_pull), .rx_flush(rx_flush),
    .tx_flush(tx_flush), .tx_push(tx_push), .tx_char(tx_char), .baud_cfg(baud_cfg)
  );

  // per status bit: enable bit, set bit, clear bit (from R3, R5, R9)
  int ie_of  [6] = '{0, 5, 1, 2, 3, 4};
  int set_of [6] = '{5, 14, 6, 7, 8, 9};
  int clr_of [6] = '{0, 13, 1, 2, 3, 4};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'd4, v);  check("R1 ctrl", v, 32'h0);
    rd(5'd8, v);  check("R1 baud", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rd(5'd16, v); check("R1 status flags", v[5:0], 32'h2);

    // R2 readback
    wr(5'd4, 32'hFFFF_FFFF); rd(5'd4, v); check("R2 ctrl readback", v, 32'h03FF_FFFF);
    wr(5'd4, 32'h0);
    wr(5'd8, 32'hABCD_1234); rd(5'd8, v); check("R2 baud readback", v, 32'h1234);
    check("R2 baud_cfg", {16'b0, baud_cfg}, 32'h1234);
    rx_head = 8'hA5; rd(5'd0, v); check("R2 data read", v, 32'hA5);
    rd(5'd12, v); check("R2 cmd reads zero", v, 32'h0);

    // R3 count fields
    rx_count = 5'd13; tx_count = 5'd7;
    rd(5'd16, v);
    check("R3 rx count field", v[10:6], 32'd13);
    check("R3 tx count field", v[15:11], 32'd7);
    rx_count = 5'd0; tx_count = 5'd16;
    wr(5'd12, 32'h201F);

    // R4 error pulses
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ev[k] = 1'b1;
      @(negedge clk); ev[k] = 1'b0;
      rd(5'd16, v); check("R4 error pulse sets flag", v[5:0], 32'(1 << (k + 2)));
      @(negedge clk);
      rd(5'd16, v); check("R4 error flag sticks", v[5:0], 32'(1 << (k + 2)));
      wr(5'd12, 32'h1F);
    end

    // R5 set and clear each flag through the command word
    for (int f = 0; f < 6; f++) begin
      wr(5'd12, 32'(1 << set_of[f]));
      rd(5'd16, v); check("R5 set bit", v[5:0], 32'(1 << f));
      wr(5'd12, 32'(1 << clr_of[f]));
      rd(5'd16, v); check("R5 clear bit", v[5:0], 32'h0);
    end

    // R6 priorities
    @(negedge clk);
    ev[2] = 1'b1; bus_addr = 5'd12; bus_wdata = 32'(1 << 3); bus_wr = 1'b1;
    @(negedge clk);
    ev[2] = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    rd(5'd16, v); check("R6 event beats clear", v[4], 32'h1);
    wr(5'd12, 32'h1F);
    wr(5'd12, 32'(1 << 9) | 32'(1 << 4));
    rd(5'd16, v); check("R6 set beats clear", v[5], 32'h1);
    wr(5'd12, 32'h1F);
    tx_count = 5'd0;
    wr(5'd12, 32'(1 << 13));
    rd(5'd16, v); check("R6 threshold beats trdy clear", v[1], 32'h1);

    // R7 threshold sweep
    for (int t = 0; t < 16; t++) begin
      for (int c = 0; c <= 16; c++) begin
        tx_count = 5'(c);
        wr(5'd4, 32'(t) << 22);
        wr(5'd12, 32'(1 << 13));
        rd(5'd16, v);
        check("R7 trdy vs threshold", v[1], (c <= t) ? 32'h1 : 32'h0);
      end
    end
    tx_count = 5'd16;
    wr(5'd4, 32'h0);
    wr(5'd12, 32'(1 << 13));

    // R8 receive delay
    for (int n = 0; n < 4; n++) begin
      int d;
      d = (n == 0) ? 0 : (n == 1) ? 1 : (n == 2) ? 3 : 7;
      rx_count = 5'd0;
      wr(5'd4, 32'(d) << 14);
      ticks(2);
      wr(5'd12, 32'h1);
      rx_count = 5'd1;
      if (d > 0) begin
        ticks(d - 1);
        repeat (3) @(negedge clk);
        rd(5'd16, v); check("R8 rrdy before delay", v[0], 32'h0);
        ticks(1);
      end
      @(negedge clk);
      rd(5'd16, v); check("R8 rrdy after delay", v[0], 32'h1);
    end
    // restart on drain
    rx_count = 5'd0;
    wr(5'd4, 32'(4) << 14);
    wr(5'd12, 32'h1);
    rx_count = 5'd2;
    ticks(3);
    rx_count = 5'd0;
    @(negedge clk);
    rx_count = 5'd1;
    ticks(3);
    @(negedge clk);
    rd(5'd16, v); check("R8 count restarts on drain", v[0], 32'h0);
    ticks(1);
    @(negedge clk);
    rd(5'd16, v); check("R8 rrdy after restarted delay", v[0], 32'h1);
    rx_count = 5'd0;
    wr(5'd4, 32'h0);
    wr(5'd12, 32'h201F);

    // R9 enable mapping
    for (int f = 0; f < 6; f++) begin
      wr(5'd4, 32'h0);
      wr(5'd12, 32'h201F);
      wr(5'd12, 32'(1 << set_of[f]));
      check("R9 irq masked", {31'b0, irq}, 32'h0);
      for (int j = 0; j < 6; j++) begin
        wr(5'd4, 32'(1 << j));
        #1 check("R9 irq per enable", {31'b0, irq}, (ie_of[f] == j) ? 32'h1 : 32'h0);
      end
    end
    wr(5'd4, 32'h3F);
    wr(5'd12, 32'h201F);
    #1 check("R9 irq low with no flags", {31'b0, irq}, 32'h0);
    wr(5'd4, 32'h0);

    // R10 strobes
    for (int b = 10; b < 13; b++) begin
      @(negedge clk);
      bus_addr = 5'd12; bus_wdata = 32'(1 << b); bus_wr = 1'b1;
      #1 check("R10 strobe during write", {29'b0, tx_flush, rx_flush, rx_pull}, 32'(1 << (b - 10)));
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      #1 check("R10 strobe one cycle", {29'b0, tx_flush, rx_flush, rx_pull}, 32'h0);
    end
    @(negedge clk);
    bus_addr = 5'd0; bus_wdata = 32'h0000_013C; bus_wr = 1'b1;
    #1 check("R10 tx push", {23'b0, tx_push, tx_char}, 32'h13C);
    @(negedge clk);
    bus_wr = 1'b0;
    #1 check("R10 tx push ends", {31'b0, tx_push}, 32'h0);

    done = 1;
    summary();
  end

endmodule